// File: doc/BRIEF.md
# Radio Control Command Block Sender

This block turns one high-level radio control request into the fixed five-byte command block that a transceiver's computer-control port expects, and shifts that block out on an asynchronous serial line. The supported requests are: tune to a frequency, select an operating mode, select the repeater shift, and key or unkey the transmitter. The block assembles four argument bytes, fills any argument slot the command does not use with 00, and sends the opcode as the last of the five bytes.

A host presents a request with a one-cycle `cmdValid` together with the command kind and a 32-bit argument. The block takes the request only while it is idle. It raises `busy` for the whole block and pulses `done` once the last stop bit has gone out. The bit rate comes from an internal divider set by the clock frequency and baud parameters. The five bytes follow one another with no gap, which keeps them far inside the line's 200 ms limit between bytes.

Top module: `radio_cmd_sender`

## Requirements
- R1: Every accepted request produces exactly five bytes on `txd`. Bytes one to four carry arguments or padding, and byte five is the opcode.
- R2: Each byte is sent as one start bit (0), eight data bits with the least significant bit first, no parity bit, and two stop bits (1). Every bit lasts CLK_HZ/BAUD clock cycles, and the next byte's start bit follows the previous byte's second stop bit directly. The start bit of the first byte begins in the cycle after acceptance.
- R3: `cmdKind` = 0 (frequency) sends `cmdArg[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` in that order, then opcode 01. The argument holds packed BCD digit pairs, most significant first. For example, 01 42 34 56 selects 14.23456 MHz.
- R4: `cmdKind` = 1 (operating mode) sends `cmdArg[7:0]` as the mode code, then 00 00 00, then opcode 07. The mode codes are 00 LSB, 01 USB, 02 CW, 03 CW-reverse, 04 AM, 08 FM, 88 narrow FM, 0A digital and 0C packet.
- R5: `cmdKind` = 2 (repeater shift) sends `cmdArg[7:0]` as the shift code (09 minus, 49 plus, 89 simplex), then 00 00 00, then opcode 09.
- R6: `cmdKind` = 3 (transmit keying) sends 00 00 00 00 and then an opcode of 08 when `cmdArg[0]` is 1 (transmit) or 88 when it is 0 (receive).
- R7: A request is taken when `cmdValid` is high at a clock edge while `busy` is low. `busy` is high from the cycle after acceptance until the block ends. A request made while `busy` is high has no effect on the bytes sent, now or later.
- R8: `done` is high for exactly one cycle: the cycle right after the second stop bit of the fifth byte ends. That is 55·CLK_HZ/BAUD cycles after the accepting edge. `busy` is low in that cycle.
- R9: `txd` is high during reset and at all times while `busy` is low. Both `busy` and `done` are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Request strobe |
| cmdKind | input | 2 | 0 frequency, 1 mode, 2 repeater shift, 3 transmit keying |
| cmdArg | input | 32 | Command argument (see R3 to R6) |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle pulse at the end of a block |
| txd | output | 1 | Serial output, idles high |

## Verification
The hardest situation to reach from the ports is a second request that arrives while a block is in flight. It must leave no mark: no altered byte and no extra block afterwards. The stimulus raises `cmdValid` with a different command part way through a frequency block. It then keeps watching the line after `done` to confirm that only the original five bytes appeared. A UART receiver model in the bench samples every bit at its centre and checks both stop bits, so framing faults are caught as well as wrong byte values.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int BLOCK_BYTES = 5;

  localparam logic [7:0] OP_FREQ    = 8'h01;
  localparam logic [7:0] OP_MODE    = 8'h07;
  localparam logic [7:0] OP_SHIFT   = 8'h09;
  localparam logic [7:0] OP_KEY_ON  = 8'h08;
  localparam logic [7:0] OP_KEY_OFF = 8'h88;
  localparam logic [7:0] PAD_BYTE   = 8'h00;

  typedef enum logic [1:0] {
    KIND_FREQ  = 2'd0,
    KIND_MODE  = 2'd1,
    KIND_SHIFT = 2'd2,
    KIND_KEY   = 2'd3
  } cmd_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new block, start the first byte
    logic shift;     // advance one bit within the current byte
    logic nextByte;  // move to the next pending byte
    logic finish;    // last stop bit of the last byte has ended
  } tx_strobe_t;

  // first byte on the wire sits in the top eight bits, the opcode in the bottom eight
  function automatic logic [8*BLOCK_BYTES-1:0] build_block(input logic [1:0] kind,
                                                           input logic [31:0] arg);
    logic [8*BLOCK_BYTES-1:0] blk;
    case (cmd_kind_e'(kind))
      KIND_FREQ:  blk = {arg, OP_FREQ};
      KIND_MODE:  blk = {arg[7:0], PAD_BYTE, PAD_BYTE, PAD_BYTE, OP_MODE};
      KIND_SHIFT: blk = {arg[7:0], PAD_BYTE, PAD_BYTE, PAD_BYTE, OP_SHIFT};
      default:    blk = {PAD_BYTE, PAD_BYTE, PAD_BYTE, PAD_BYTE,
                         (arg[0] ? OP_KEY_ON : OP_KEY_OFF)};
    endcase
    return blk;
  endfunction

endpackage

// File: rtl/rcs_baud.sv
module rcs_baud #(
  parameter int CLKS_PER_BIT = 5208
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST_COUNT = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] count;

  assign tick = run && (count == LAST_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) count <= '0;
    else if (tick)      count <= '0;
    else                count <= count + 1'b1;
  end
endmodule

// File: rtl/rcs_control.sv
module rcs_control
  import rcs_pkg::*;
#(
  parameter int STOP_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmdValid,
  input  logic       tick,
  output tx_strobe_t stb,
  output logic       busy,
  output logic       done
);
  localparam int FRAME_BITS = 1 + 8 + STOP_BITS;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int BYTE_W     = $clog2(BLOCK_BYTES);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(FRAME_BITS - 1);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(BLOCK_BYTES - 1);

  typedef enum logic {S_IDLE, S_SEND} state_e;

  state_e            state;
  logic [BIT_W-1:0]  bitIdx;
  logic [BYTE_W-1:0] byteIdx;
  logic              frameEnd;

  assign busy     = (state == S_SEND);
  assign frameEnd = busy && tick && (bitIdx == LAST_BIT);

  always_comb begin
    stb          = '0;
    stb.load     = (state == S_IDLE) && cmdValid;
    stb.shift    = busy && tick && (bitIdx != LAST_BIT);
    stb.nextByte = frameEnd && (byteIdx != LAST_BYTE);
    stb.finish   = frameEnd && (byteIdx == LAST_BYTE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      bitIdx  <= '0;
      byteIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.load) begin
        state   <= S_SEND;
        bitIdx  <= '0;
        byteIdx <= '0;
      end else if (stb.shift) begin
        bitIdx <= bitIdx + 1'b1;
      end else if (stb.nextByte) begin
        bitIdx  <= '0;
        byteIdx <= byteIdx + 1'b1;
      end else if (stb.finish) begin
        state <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/rcs_datapath.sv
module rcs_datapath
  import rcs_pkg::*;
#(
  parameter int STOP_BITS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  tx_strobe_t  stb,
  input  logic [1:0]  cmdKind,
  input  logic [31:0] cmdArg,
  output logic        txd
);
  localparam int FRAME_BITS = 1 + 8 + STOP_BITS;
  localparam int BLK_BITS   = 8 * BLOCK_BYTES;
  localparam int PEND_BITS  = BLK_BITS - 8;

  logic [FRAME_BITS-1:0] frame;
  logic [PEND_BITS-1:0]  pend;
  logic [BLK_BITS-1:0]   block;

  function automatic logic [FRAME_BITS-1:0] frameOf(input logic [7:0] b);
    return {{STOP_BITS{1'b1}}, b, 1'b0};
  endfunction

  assign block = build_block(cmdKind, cmdArg);
  assign txd   = frame[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame <= '1;
      pend  <= '0;
    end else if (stb.load) begin
      frame <= frameOf(block[BLK_BITS-1 -: 8]);
      pend  <= block[PEND_BITS-1:0];
    end else if (stb.nextByte) begin
      frame <= frameOf(pend[PEND_BITS-1 -: 8]);
      pend  <= pend << 8;
    end else if (stb.shift) begin
      frame <= {1'b1, frame[FRAME_BITS-1:1]};
    end else if (stb.finish) begin
      frame <= '1;
    end
  end
endmodule

// File: rtl/radio_cmd_sender.sv
module radio_cmd_sender
  import rcs_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int BAUD      = 9600,
  parameter int STOP_BITS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  logic [1:0]  cmdKind,
  input  logic [31:0] cmdArg,
  output logic        busy,
  output logic        done,
  output logic        txd
);
  localparam int CLKS_PER_BIT = CLK_HZ / BAUD;

  tx_strobe_t stb;
  logic       tick;

  rcs_baud #(.CLKS_PER_BIT(CLKS_PER_BIT)) baud_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  rcs_control #(.STOP_BITS(STOP_BITS)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .tick(tick),
    .stb(stb), .busy(busy), .done(done)
  );

  rcs_datapath #(.STOP_BITS(STOP_BITS)) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cmdKind(cmdKind),
    .cmdArg(cmdArg), .txd(txd)
  );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker (
  input logic clk,
  input logic rst_n,
  input logic cmdValid,
  input logic busy,
  input logic done,
  input logic txd
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);  // R9
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && !busy) |=> busy);  // R7
  AST_START_BIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);  // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R8
  AST_DONE_ENDS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));  // R8
endmodule

bind radio_cmd_sender rcs_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid),
  .busy(busy), .done(done), .txd(txd)
);

// File: tb/radio_cmd_sender_tb_top.sv
`timescale 1ns/1ps
module radio_cmd_sender_tb_top;
  localparam int CPB = 8;
  localparam int BLOCK_CYCLES = 55 * CPB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdKind = 2'd0;
  logic [31:0] cmdArg = 32'h0;
  logic        busy, done, txd;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  radio_cmd_sender #(.CLK_HZ(CPB * 100), .BAUD(100), .STOP_BITS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdArg(cmdArg), .busy(busy), .done(done), .txd(txd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  // expected bytes, worked out from R3..R6
  task automatic pushExpected(input logic [1:0] kind, input logic [31:0] arg);
    case (kind)
      2'd0: begin expQ.push_back(arg[31:24]); expQ.push_back(arg[23:16]);
                  expQ.push_back(arg[15:8]);  expQ.push_back(arg[7:0]);
                  expQ.push_back(8'h01); end
      2'd1: begin expQ.push_back(arg[7:0]); repeat (3) expQ.push_back(8'h00);
                  expQ.push_back(8'h07); end
      2'd2: begin expQ.push_back(arg[7:0]); repeat (3) expQ.push_back(8'h00);
                  expQ.push_back(8'h09); end
      default: begin repeat (4) expQ.push_back(8'h00);
                  expQ.push_back(arg[0] ? 8'h08 : 8'h88); end
    endcase
  endtask

  // driver: one request, optional ignored request while busy, then timing of done
  task automatic sendCmd(input logic [1:0] kind, input logic [31:0] arg,
                         input string req, input bit injectIgnored);
    int n;
    int doneAt;
    bit busyOk;
    pushExpected(kind, arg);
    @(negedge clk);
    cmdKind = kind; cmdArg = arg; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; cmdArg = 32'hDEAD_BEEF;
    check(busy === 1'b1, "R7", "busy after accept", {31'd0, busy}, 1);
    n = 0; doneAt = -1; busyOk = 1'b1;
    while (doneAt < 0 && n < 2 * BLOCK_CYCLES) begin
      @(negedge clk);
      n++;
      if (done === 1'b1) doneAt = n;
      else if (busy !== 1'b1) busyOk = 1'b0;
      if (injectIgnored && n == 20 * CPB) begin
        cmdKind = 2'd3; cmdArg = 32'h1; cmdValid = 1'b1;
      end
      if (injectIgnored && n == 20 * CPB + 1) cmdValid = 1'b0;
    end
    check(doneAt == BLOCK_CYCLES, req, "done cycle after accept", doneAt, BLOCK_CYCLES);
    check(busyOk, "R7", "busy held through block", {31'd0, busyOk}, 1);
    check(busy === 1'b0, "R8", "busy low with done", {31'd0, busy}, 0);
    @(negedge clk);
    check(done === 1'b0, "R8", "done width one cycle", {31'd0, done}, 0);
    check(expQ.size() == 0, "R1", "bytes left unsent", expQ.size(), 0);
  endtask

  // monitor: centre-sampling receiver, pops and compares
  always begin
    logic [7:0] rx;
    logic [7:0] ex;
    @(negedge clk);
    if (rst_n === 1'b1 && txd === 1'b0) begin
      repeat (CPB / 2) @(negedge clk);
      check(txd === 1'b0, "R2", "start bit", {31'd0, txd}, 0);
      for (int i = 0; i < 8; i++) begin
        repeat (CPB) @(negedge clk);
        rx[i] = txd;
      end
      for (int s = 0; s < 2; s++) begin
        repeat (CPB) @(negedge clk);
        check(txd === 1'b1, "R2", "stop bit", {31'd0, txd}, 1);
      end
      if (expQ.size() == 0) begin
        check(1'b0, "R7", "unexpected byte", {24'd0, rx}, 0);
      end else begin
        ex = expQ.pop_front();
        check(rx === ex, "R1", "byte value", {24'd0, rx}, {24'd0, ex});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R9", "txd in reset", {31'd0, txd}, 1);
    check(busy === 1'b0, "R9", "busy in reset", {31'd0, busy}, 0);
    check(done === 1'b0, "R9", "done in reset", {31'd0, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(txd === 1'b1, "R9", "idle line", {31'd0, txd}, 1);

    sendCmd(2'd0, 32'h0142_3456, "R3", 1'b0);  // R3 14.23456 MHz
    sendCmd(2'd1, 32'h0000_0088, "R4", 1'b0);  // R4 narrow FM
    sendCmd(2'd1, 32'h0000_000C, "R4", 1'b0);  // R4 packet
    sendCmd(2'd2, 32'h0000_0049, "R5", 1'b0);  // R5 plus shift
    sendCmd(2'd2, 32'h0000_0089, "R5", 1'b0);  // R5 simplex
    sendCmd(2'd3, 32'h0000_0001, "R6", 1'b0);  // R6 transmit
    sendCmd(2'd3, 32'h0000_0000, "R6", 1'b0);  // R6 receive
    sendCmd(2'd0, 32'h0714_2500, "R7", 1'b1);  // R7 request while busy ignored

    repeat (30 * CPB) @(negedge clk);
    check(busy === 1'b0, "R7", "no block from ignored request", {31'd0, busy}, 0);
    check(txd === 1'b1, "R9", "line high after ignored request", {31'd0, txd}, 1);
    check(expQ.size() == 0, "R7", "queue empty at end", expQ.size(), 0);
    summary();
    $finish;
  end
endmodule